// File: doc/BRIEF.md
# Programmable Address Decode Window Unit

This unit steers each CPU transaction to a destination port by comparing its 32-bit address against a small bank of programmable windows. Every window holds an enable flag, a 4-bit destination code, a base, a size mask and a remap base. The base, size and remap values all count in 64 KB steps, so the low 16 address bits never take part in a match. When a window hits, the unit reports the destination code and the window number. It also returns a translated address: the high bits that the size mask covers come from the incoming address, and the remaining high bits come from the remap base.

Software programs the windows through a narrow register port. Each register location is selected by a window number and a register selector. The advised update order for a live window is:

1. Drop the enable flag.
2. Write the base, then the remap base, then the size.
3. Write the destination code and set the enable flag.

Window 0 leaves reset already enabled toward DRAM from address 0, so a processor can boot before the other windows are programmed. Decode is combinational from the address input. By default one register stage follows the decode.

Top module: `addr_win_decoder`

## Requirements
- R1: The unit has `NUM_WIN` windows (default five). Each window is programmed independently, and `dec_win` reports the index of the winning window, always below `NUM_WIN`.
- R2: Address bits 15:0 pass from `in_addr` to `dec_addr` unchanged, both on a hit and on a miss.
- R3: A window with size field S and base field B matches when `(in_addr[31:16] & ~S) == (B & ~S)`. A size field with k low ones spans 2^k × 64 KB, for example 0x07FF spans 128 MB.
- R4: On a hit, `dec_addr[31:16]` = `(remap & ~S) | (in_addr[31:16] & S)`.
- R5: A window whose enable bit is clear never produces a hit, and clearing the enable bit alone removes its decode.
- R6: When several enabled windows match, the lowest-numbered one wins.
- R7: On a miss, `dec_hit` is 0, `dec_tgt` is 4'hF, `dec_win` is 0 and `dec_addr` equals `in_addr`.
- R8: After reset, window 0 is enabled with destination 0 (DRAM), base 0, remap 0 and size `BOOT_SIZE` (default 0x7FFF, 2 GB). All other windows read back as zero, and `cfg_err` is 0.
- R9: `cfg_addr` is {window[2:0], selector[1:0]}, with selector 0 = control, 1 = base, 2 = size and 3 = remap. The control word holds the enable flag in bit 0 and the destination code in bits 7:4, and reads zero elsewhere. Destination codes are 0 DRAM, 1 internal registers, 2 PCIe, 3 PCIe through the bridge, 4 boot ROM, 5 external bridge, 7 secure RAM and 8 interconnect registers. Reads are combinational. Writes to window numbers at or above `NUM_WIN` are ignored, and those locations read zero.
- R10: Writing a size value that is not a run of ones from bit 0 upward sets `cfg_err`. The flag stays set until reset, and the value is still applied as a raw mask.
- R11: With `OUT_REG` = 1, decode results appear on the outputs one clock after `in_addr` is presented. A register write affects decode from the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | {window index, register selector} |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| cfg_err | output | 1 | Sticky flag for a non-contiguous size write |
| in_addr | input | 32 | Transaction address to decode |
| dec_hit | output | 1 | A window matched |
| dec_tgt | output | 4 | Destination code, 4'hF on a miss |
| dec_win | output | 3 | Index of the winning window |
| dec_addr | output | 32 | Translated address |

## Verification
On every cycle, the embedded properties check the following:
- The priority grant selects at most one window, and any granted window is enabled.
- A registered miss always carries the all-ones destination.
- The reported window index stays in range.
- `cfg_err` never drops once it is set.

Only the bench's scenarios can show the arithmetic of the mask compare and the remap merge, and the lowest-index choice between overlapping windows. The same holds for the reset layout, the readback format, and the raw-mask use of a malformed size.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int AWD_ADDR_W       = 32;
  localparam int AWD_GRAN_W       = 16;
  localparam int AWD_FLD_W        = AWD_ADDR_W - AWD_GRAN_W;
  localparam int AWD_TGT_W        = 4;
  localparam int AWD_DATA_W       = 16;
  localparam int AWD_CTRL_EN_BIT  = 0;
  localparam int AWD_CTRL_TGT_LSB = 4;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_SIZE  = 2'd2,
    SEL_REMAP = 2'd3
  } awd_sel_e;

  typedef enum logic [AWD_TGT_W-1:0] {
    TGT_DRAM     = 4'd0,
    TGT_IREG     = 4'd1,
    TGT_PCIE     = 4'd2,
    TGT_PCIE_BRG = 4'd3,
    TGT_BROM     = 4'd4,
    TGT_XBRG     = 4'd5,
    TGT_SRAM     = 4'd7,
    TGT_FABRIC   = 4'd8,
    TGT_NONE     = 4'hF
  } awd_tgt_e;

  typedef struct packed {
    logic                 en;
    logic [AWD_TGT_W-1:0] tgt;
    logic [AWD_FLD_W-1:0] base;
    logic [AWD_FLD_W-1:0] size;
    logic [AWD_FLD_W-1:0] remap;
  } awd_win_t;

  // True when the value is a run of ones starting at bit 0 (zero included).
  function automatic logic awd_is_run(input logic [AWD_FLD_W-1:0] v);
    logic [AWD_FLD_W-1:0] inc;
    inc = v + AWD_FLD_W'(1);
    return ((v & inc) == '0);
  endfunction
endpackage

// File: rtl/awd_win_regs.sv
module awd_win_regs
  import awd_pkg::*;
#(
  parameter logic                 RST_EN    = 1'b0,
  parameter logic [AWD_TGT_W-1:0] RST_TGT   = '0,
  parameter logic [AWD_FLD_W-1:0] RST_BASE  = '0,
  parameter logic [AWD_FLD_W-1:0] RST_SIZE  = '0,
  parameter logic [AWD_FLD_W-1:0] RST_REMAP = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  awd_sel_e              wr_sel,
  input  logic [AWD_DATA_W-1:0] wr_data,
  output awd_win_t              cfg,
  output logic                  size_bad
);

  awd_win_t cfg_q;
  awd_win_t cfg_n;
  logic     cfg_ce;

  always_comb begin
    cfg_n    = cfg_q;
    cfg_ce   = wr_en;
    size_bad = 1'b0;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_CTRL: begin
          cfg_n.en  = wr_data[AWD_CTRL_EN_BIT];
          cfg_n.tgt = wr_data[AWD_CTRL_TGT_LSB +: AWD_TGT_W];
        end
        SEL_BASE:  cfg_n.base  = wr_data[AWD_FLD_W-1:0];
        SEL_SIZE: begin
          cfg_n.size = wr_data[AWD_FLD_W-1:0];
          size_bad   = !awd_is_run(wr_data[AWD_FLD_W-1:0]);
        end
        SEL_REMAP: cfg_n.remap = wr_data[AWD_FLD_W-1:0];
        default:   cfg_n = cfg_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.en    <= RST_EN;
      cfg_q.tgt   <= RST_TGT;
      cfg_q.base  <= RST_BASE;
      cfg_q.size  <= RST_SIZE;
      cfg_q.remap <= RST_REMAP;
    end else if (cfg_ce) begin
      cfg_q <= cfg_n;
    end
  end

  assign cfg = cfg_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q)) else $error("window config changed without write"); // R9

endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
  import awd_pkg::*;
(
  input  awd_win_t              cfg,
  input  logic [AWD_FLD_W-1:0]  addr_hi,
  output logic                  match,
  output logic [AWD_FLD_W-1:0]  xlat_hi
);

  logic [AWD_FLD_W-1:0] keep_mask;

  always_comb begin
    keep_mask = ~cfg.size;
    match     = cfg.en && ((addr_hi & keep_mask) == (cfg.base & keep_mask));
    xlat_hi   = (cfg.remap & keep_mask) | (addr_hi & cfg.size);
  end

endmodule

// File: rtl/awd_prio_sel.sv
module awd_prio_sel
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int IDX_W   = 3,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_WIN-1:0]                   match,
  input  logic [NUM_WIN-1:0]                   en_vec,
  input  logic [NUM_WIN-1:0][AWD_TGT_W-1:0]    tgt_arr,
  input  logic [NUM_WIN-1:0][AWD_FLD_W-1:0]    xlat_arr,
  input  logic [AWD_ADDR_W-1:0]                addr,
  output logic                                 hit,
  output logic [AWD_TGT_W-1:0]                 tgt,
  output logic [IDX_W-1:0]                     idx,
  output logic [AWD_ADDR_W-1:0]                out_addr
);

  logic [NUM_WIN-1:0]     grant;
  logic                   hit_n;
  logic [AWD_TGT_W-1:0]   tgt_n;
  logic [IDX_W-1:0]       idx_n;
  logic [AWD_ADDR_W-1:0]  addr_n;

  always_comb begin
    grant  = '0;
    hit_n  = 1'b0;
    idx_n  = '0;
    tgt_n  = TGT_NONE;
    addr_n = addr;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (match[i] && !hit_n) begin
        hit_n    = 1'b1;
        grant[i] = 1'b1;
        idx_n    = IDX_W'(i);
        tgt_n    = tgt_arr[i];
        addr_n   = {xlat_arr[i], addr[AWD_GRAN_W-1:0]};
      end
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      logic                  hit_q;
      logic [AWD_TGT_W-1:0]  tgt_q;
      logic [IDX_W-1:0]      idx_q;
      logic [AWD_ADDR_W-1:0] addr_q;
      logic                  out_ce;

      assign out_ce = 1'b1;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hit_q  <= 1'b0;
          tgt_q  <= TGT_NONE;
          idx_q  <= '0;
          addr_q <= '0;
        end else if (out_ce) begin
          hit_q  <= hit_n;
          tgt_q  <= tgt_n;
          idx_q  <= idx_n;
          addr_q <= addr_n;
        end
      end

      assign hit      = hit_q;
      assign tgt      = tgt_q;
      assign idx      = idx_q;
      assign out_addr = addr_q;
    end else begin : g_comb
      assign hit      = hit_n;
      assign tgt      = tgt_n;
      assign idx      = idx_n;
      assign out_addr = addr_n;
    end
  endgenerate

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)) else $error("more than one window granted"); // R6

  AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    hit_n |-> ((grant & en_vec) == grant)) else $error("disabled window granted"); // R5

endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import awd_pkg::*;
#(
  parameter int                   NUM_WIN   = 5,
  parameter bit                   OUT_REG   = 1'b1,
  parameter logic [AWD_FLD_W-1:0] BOOT_SIZE = 16'h7FFF,
  localparam int                  IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int                  CFG_AW    = IDX_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [CFG_AW-1:0]      cfg_addr,
  input  logic [AWD_DATA_W-1:0]  cfg_wdata,
  output logic [AWD_DATA_W-1:0]  cfg_rdata,
  output logic                   cfg_err,
  input  logic [AWD_ADDR_W-1:0]  in_addr,
  output logic                   dec_hit,
  output logic [AWD_TGT_W-1:0]   dec_tgt,
  output logic [IDX_W-1:0]       dec_win,
  output logic [AWD_ADDR_W-1:0]  dec_addr
);

  logic [IDX_W-1:0]                cfg_win;
  awd_sel_e                        cfg_sel;
  awd_win_t                        win_cfg [NUM_WIN];
  logic [NUM_WIN-1:0]              bad_vec;
  logic [NUM_WIN-1:0]              match_vec;
  logic [NUM_WIN-1:0]              en_vec;
  logic [NUM_WIN-1:0][AWD_TGT_W-1:0] tgt_arr;
  logic [NUM_WIN-1:0][AWD_FLD_W-1:0] xlat_arr;
  logic                            err_q;
  logic                            err_n;
  logic                            err_ce;

  assign cfg_win = cfg_addr[CFG_AW-1:2];
  assign cfg_sel = awd_sel_e'(cfg_addr[1:0]);

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      awd_win_regs #(
        .RST_EN    (w == 0),
        .RST_TGT   (TGT_DRAM),
        .RST_BASE  ('0),
        .RST_SIZE  ((w == 0) ? BOOT_SIZE : '0),
        .RST_REMAP ('0)
      ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we && (cfg_win == IDX_W'(w))),
        .wr_sel   (cfg_sel),
        .wr_data  (cfg_wdata),
        .cfg      (win_cfg[w]),
        .size_bad (bad_vec[w])
      );

      awd_win_match u_match (
        .cfg     (win_cfg[w]),
        .addr_hi (in_addr[AWD_ADDR_W-1:AWD_GRAN_W]),
        .match   (match_vec[w]),
        .xlat_hi (xlat_arr[w])
      );

      assign en_vec[w]  = win_cfg[w].en;
      assign tgt_arr[w] = win_cfg[w].tgt;
    end
  endgenerate

  awd_prio_sel #(
    .NUM_WIN (NUM_WIN),
    .IDX_W   (IDX_W),
    .OUT_REG (OUT_REG)
  ) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .match    (match_vec),
    .en_vec   (en_vec),
    .tgt_arr  (tgt_arr),
    .xlat_arr (xlat_arr),
    .addr     (in_addr),
    .hit      (dec_hit),
    .tgt      (dec_tgt),
    .idx      (dec_win),
    .out_addr (dec_addr)
  );

  // Register read mux
  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (cfg_win == IDX_W'(w)) begin
        unique case (cfg_sel)
          SEL_CTRL: begin
            cfg_rdata[AWD_CTRL_EN_BIT]                   = win_cfg[w].en;
            cfg_rdata[AWD_CTRL_TGT_LSB +: AWD_TGT_W]     = win_cfg[w].tgt;
          end
          SEL_BASE:  cfg_rdata[AWD_FLD_W-1:0] = win_cfg[w].base;
          SEL_SIZE:  cfg_rdata[AWD_FLD_W-1:0] = win_cfg[w].size;
          SEL_REMAP: cfg_rdata[AWD_FLD_W-1:0] = win_cfg[w].remap;
          default:   cfg_rdata = '0;
        endcase
      end
    end
  end

  // Sticky configuration error
  always_comb begin
    err_ce = |bad_vec;
    err_n  = err_q | (|bad_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_ce) begin
      err_q <= err_n;
    end
  end

  assign cfg_err = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err) else $error("config error flag dropped"); // R10

  AST_MISS_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_hit |-> (dec_tgt == TGT_NONE)) else $error("miss without all-ones target"); // R7

  AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_win < IDX_W'(NUM_WIN)) else $error("window index out of range"); // R1

endmodule

// File: tb/addr_win_decoder_tb_top.sv
module addr_win_decoder_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        cfg_err;
  logic [31:0] in_addr;
  logic        dec_hit;
  logic [3:0]  dec_tgt;
  logic [2:0]  dec_win;
  logic [31:0] dec_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  addr_win_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .in_addr(in_addr), .dec_hit(dec_hit), .dec_tgt(dec_tgt),
    .dec_win(dec_win), .dec_addr(dec_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [31:0] a;
    logic        hit;
    logic [3:0]  tgt;
    logic [2:0]  win;
    logic [31:0] o;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 1'b1, 4'h0, 3'd0, 32'h0000_0000},  // R3 boot window low edge
    '{32'h7FFF_FFFF, 1'b1, 4'h0, 3'd0, 32'h7FFF_FFFF},  // R3 boot window high edge
    '{32'h8000_0000, 1'b1, 4'h3, 3'd4, 32'h8000_0000},  // R1 window 4
    '{32'h8FFF_ABCD, 1'b1, 4'h3, 3'd4, 32'h8FFF_ABCD},  // R3 top of 256 MB
    '{32'h9000_0000, 1'b0, 4'hF, 3'd0, 32'h9000_0000},  // R7 gap
    '{32'hE000_0000, 1'b1, 4'h5, 3'd1, 32'h1000_0000},  // R4 remapped
    '{32'hE7FF_1234, 1'b1, 4'h5, 3'd1, 32'h17FF_1234},  // R4 R2 remap merge
    '{32'hE800_0004, 1'b1, 4'h2, 3'd2, 32'hE800_0004},  // R1 window 2
    '{32'hF001_2345, 1'b1, 4'h7, 3'd3, 32'h1FFF_2345},  // R4 small window remap
    '{32'hF002_0000, 1'b0, 4'hF, 3'd0, 32'hF002_0000},  // R3 just past 128 KB
    '{32'hFFFF_FFFF, 1'b0, 4'hF, 3'd0, 32'hFFFF_FFFF}   // R7 top of space
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = {w, s};
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] w, input logic [1:0] s, input logic [15:0] e);
    @(negedge clk);
    cfg_addr = {w, s};
    #1;
    chk(req, 64'(cfg_rdata), 64'(e));
  endtask

  task automatic dec(input string req, input logic [31:0] a, input logic h,
                     input logic [3:0] t, input logic [2:0] w, input logic [31:0] o);
    @(negedge clk);
    in_addr = a;
    @(negedge clk);
    chk(req, 64'({dec_hit, dec_tgt, dec_win, dec_addr}), 64'({h, t, w, o}));
  endtask

  // Selector codes: 0 ctrl, 1 base, 2 size, 3 remap; ctrl = {tgt[7:4], en[0]}
  task automatic prog(input logic [2:0] w, input logic [15:0] b, input logic [15:0] sz,
                      input logic [15:0] rm, input logic [3:0] t);
    wr(w, 2'd0, 16'h0000);
    wr(w, 2'd1, b);
    wr(w, 2'd3, rm);
    wr(w, 2'd2, sz);
    wr(w, 2'd0, {8'h00, t, 4'h1});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; in_addr = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset err", 64'(cfg_err), 64'd0);
    chk("R8 reset hit", 64'({dec_hit, dec_tgt}), 64'({1'b0, 4'hF}));
    @(negedge clk);
    rst_n = 1'b1;

    rd("R8 w0 ctrl", 3'd0, 2'd0, 16'h0001);
    rd("R8 w0 size", 3'd0, 2'd2, 16'h7FFF);
    rd("R8 w1 ctrl", 3'd1, 2'd0, 16'h0000);
    dec("R8 boot decode", 32'h1234_5678, 1'b1, 4'h0, 3'd0, 32'h1234_5678);
    dec("R8 boot miss", 32'h9000_0010, 1'b0, 4'hF, 3'd0, 32'h9000_0010);

    prog(3'd1, 16'hE000, 16'h07FF, 16'h1000, 4'h5);
    prog(3'd2, 16'hE800, 16'h07FF, 16'hE800, 4'h2);
    prog(3'd3, 16'hF000, 16'h0001, 16'h1FFF, 4'h7);
    prog(3'd4, 16'h8000, 16'h0FFF, 16'h8000, 4'h3);
    rd("R9 w3 ctrl", 3'd3, 2'd0, 16'h0071);
    rd("R9 w3 remap", 3'd3, 2'd3, 16'h1FFF);
    rd("R9 w1 base", 3'd1, 2'd1, 16'hE000);
    wr(3'd5, 2'd1, 16'hABCD);
    rd("R9 out of range window", 3'd5, 2'd1, 16'h0000);
    #1;
    chk("R10 no err on runs", 64'(cfg_err), 64'd0);

    for (int i = 0; i < NV; i++)
      dec($sformatf("R3/R4 vector %0d", i), VECS[i].a, VECS[i].hit, VECS[i].tgt, VECS[i].win, VECS[i].o);

    // R11: output holds old result until the capturing edge
    dec("R11 setup", 32'h0000_0000, 1'b1, 4'h0, 3'd0, 32'h0000_0000);
    @(negedge clk);
    in_addr = 32'h9000_0000;
    #2;
    chk("R11 before edge", 64'(dec_hit), 64'd1);
    @(negedge clk);
    chk("R11 after edge", 64'(dec_hit), 64'd0);

    // R5: clearing enable alone removes decode
    wr(3'd1, 2'd0, 16'h0050);
    rd("R5 ctrl readback", 3'd1, 2'd0, 16'h0050);
    dec("R5 disabled window", 32'hE000_0000, 1'b0, 4'hF, 3'd0, 32'hE000_0000);

    // R6: window 1 overlaps window 4
    prog(3'd1, 16'h8000, 16'h0FFF, 16'h4000, 4'h5);
    dec("R6 lowest wins", 32'h8123_0000, 1'b1, 4'h5, 3'd1, 32'h4123_0000);

    // R10: malformed size used as raw mask
    wr(3'd2, 2'd2, 16'h00F0);
    #1;
    chk("R10 err set", 64'(cfg_err), 64'd1);
    dec("R10 raw mask hit", 32'hE8F0_0000, 1'b1, 4'h2, 3'd2, 32'hE8F0_0000);
    dec("R10 raw mask miss", 32'hE801_0000, 1'b0, 4'hF, 3'd0, 32'hE801_0000);
    wr(3'd2, 2'd2, 16'h07FF);
    #1;
    chk("R10 err sticky", 64'(cfg_err), 64'd1);

    // R8: reset again restores the boot layout
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    chk("R8 re-reset err", 64'(cfg_err), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    rd("R8 w4 cleared", 3'd4, 2'd0, 16'h0000);
    rd("R8 w0 restored", 3'd0, 2'd0, 16'h0001);
    dec("R8 w4 no decode", 32'h8000_0000, 1'b0, 4'hF, 3'd0, 32'h8000_0000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule